// File: doc/BRIEF.md
# Flow-Control Pause Request Detector

This block sits on the receive byte path of an Ethernet MAC and looks for flow-control frames that ask the local transmitter to stop sending. Each byte of a frame arrives on its own cycle with a valid strobe. A start strobe marks the first byte of the frame. A separate end strobe follows the last byte. On each byte the detector checks the destination address against the reserved multicast address for MAC control. It records the big-endian 16-bit type, opcode and pause-time words as they pass. When the frame closes, it gives a verdict.

The detector is armed only while the link runs full duplex and receive flow control is enabled. A frame sent to the control address with a type other than the MAC control type is flagged for rejection. A well-formed pause request raises a one-cycle valid pulse and presents the 16-bit pause quanta. The quanta output holds that value until the next accepted request. Timing of the actual pause and general address filtering belong to other blocks.

Top module: `mac_pause_detect`

## Requirements
- R1: A verdict (pause pulse or reject pulse) is produced only when `full_duplex` and `rx_fc_en` are both 1 in the cycle `rx_eof` is sampled; otherwise both outputs stay 0 for that frame.
- R2: Bytes 0 to 5 of the frame must equal 01, 80, C2, 00, 00, 01 in that order; a frame with any other destination produces neither output.
- R3: When the destination matches and the frame holds at least 14 bytes, bytes 12 (high) and 13 (low) form the type; any value other than 0x8808 raises `frame_reject` for exactly one cycle, the cycle after `rx_eof` is sampled.
- R4: When the destination and type match, the frame holds at least 18 bytes and bytes 14–15 equal 0x0001, `pause_valid` rises the cycle after `rx_eof` is sampled and `pause_quanta` equals bytes 16 (high) and 17 (low).
- R5: A control-typed frame whose opcode at bytes 14–15 is not 0x0001 produces neither output.
- R6: `pause_valid` lasts one cycle; `pause_quanta` changes only together with a `pause_valid` pulse and otherwise holds its value.
- R7: A frame that ends before byte 14 produces no output, and one with a correct type that ends before byte 18 produces no pause pulse.
- R8: `rx_eof` and a new `rx_sof` byte may share a cycle; the end strobe judges the old frame and the byte starts the new one, both parsed correctly.
- R9: After reset `pause_valid` and `frame_reject` are 0 and `pause_quanta` is 0.
- R10: An `rx_sof` byte arriving while a frame is still open discards the old frame and parses from the new byte at position 0.
- R11: Bytes presented after `rx_eof` and before the next `rx_sof` are ignored, and an end strobe with no open frame yields no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | A received byte is present on `rx_data` |
| rx_data | input | 8 | Received byte |
| rx_sof | input | 1 | This valid byte is the first of a frame |
| rx_eof | input | 1 | The open frame has ended (after its last byte) |
| full_duplex | input | 1 | Link operates in full duplex |
| rx_fc_en | input | 1 | Receive flow control enabled |
| frame_reject | output | 1 | One-cycle pulse: control-addressed frame with wrong type |
| pause_valid | output | 1 | One-cycle pulse: valid pause request received |
| pause_quanta | output | 16 | Pause time of the last accepted request |

## Verification
The verdict for one frame and the first byte of the next frame can land in the same cycle, because the end strobe may coincide with a start-of-frame byte. The bench provokes this by sending two pause requests back to back, with the second frame's first byte on the first frame's end cycle. It then checks that each request produces its own pulse carrying its own quanta. It also checks that the shared cycle neither corrupts the second frame's address match nor leaves stale fields that would turn into a false reject.

// File: rtl/mac_pause_pkg.sv
package mac_pause_pkg;
   localparam int BYTE_W     = 8;
   localparam int ADDR_BYTES = 6;
   localparam int OFS_TYPE   = 12;
   localparam int OFS_OP     = 14;
   localparam int OFS_QNT    = 16;
   localparam int WORD_BYTES = 2;
   localparam int NUM_WORDS  = 3;
   localparam int LAST_POS   = OFS_QNT + WORD_BYTES;
   localparam int POS_W      = $clog2(LAST_POS + 1);

   typedef enum logic [1:0] {
      VERDICT_NONE   = 2'd0,
      VERDICT_REJECT = 2'd1,
      VERDICT_PAUSE  = 2'd2
   } verdict_e;
endpackage

// File: rtl/mac_pause_pos.sv
module mac_pause_pos #(
   parameter int LIMIT = 18,
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             byte_valid,
   input  logic             restart,
   input  logic             close,
   output logic             take,
   output logic             open,
   output logic [CNT_W-1:0] pos,
   output logic [CNT_W-1:0] count
);
   generate
      if ((1 << CNT_W) <= LIMIT) begin : g_bad_width
         $error("mac_pause_pos: CNT_W too small for LIMIT");
      end
   endgenerate

   assign take = byte_valid && (open || restart);
   assign pos  = restart ? '0 : count;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count <= '0;
         open  <= 1'b0;
      end else if (byte_valid && restart) begin
         count <= CNT_W'(1);
         open  <= 1'b1;
      end else if (close) begin
         count <= '0;
         open  <= 1'b0;
      end else if (take && count != CNT_W'(LIMIT)) begin
         count <= count + 1'b1;
      end
   end

   p_count_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_W'(LIMIT));
   p_close_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (close && !(byte_valid && restart)) |=> (!open && count == '0));
endmodule

// File: rtl/mac_pause_addr.sv
module mac_pause_addr #(
   parameter int DATA_W     = 8,
   parameter int ADDR_BYTES = 6,
   parameter int CNT_W      = 5,
   parameter logic [ADDR_BYTES*DATA_W-1:0] ADDR = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take,
   input  logic              first,
   input  logic              close,
   input  logic [CNT_W-1:0]  pos,
   input  logic [DATA_W-1:0] data,
   output logic              match
);
   localparam int ADDR_W = ADDR_BYTES * DATA_W;

   logic [ADDR_BYTES-1:0] hit;
   logic                  sel;

   for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_cmp
      assign hit[g] = (data == ADDR[ADDR_W-1-g*DATA_W -: DATA_W]);
   end

   always_comb begin
      sel = 1'b0;
      for (int i = 0; i < ADDR_BYTES; i++) begin
         if (pos == CNT_W'(i)) sel = hit[i];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         match <= 1'b0;
      end else if (take && first) begin
         match <= hit[0];
      end else if (close) begin
         match <= 1'b0;
      end else if (take && pos < CNT_W'(ADDR_BYTES)) begin
         match <= match & sel;
      end
   end

   p_match_needs_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (close && !(take && first)) |=> !match);
endmodule

// File: rtl/mac_pause_fields.sv
module mac_pause_fields #(
   parameter int DATA_W     = 8,
   parameter int WORD_BYTES = 2,
   parameter int NUM_WORDS  = 3,
   parameter int BASE       = 12,
   parameter int CNT_W      = 5
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  take,
   input  logic [CNT_W-1:0]                      pos,
   input  logic [DATA_W-1:0]                     data,
   output logic [NUM_WORDS-1:0][WORD_BYTES*DATA_W-1:0] words
);
   for (genvar f = 0; f < NUM_WORDS; f++) begin : g_word
      for (genvar b = 0; b < WORD_BYTES; b++) begin : g_byte
         localparam int P  = BASE + f*WORD_BYTES + b;
         localparam int HI = (WORD_BYTES - b) * DATA_W - 1;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               words[f][HI -: DATA_W] <= '0;
            end else if (take && pos == CNT_W'(P)) begin
               words[f][HI -: DATA_W] <= data;
            end
         end
      end
   end
endmodule

// File: rtl/mac_pause_detect.sv
module mac_pause_detect
   import mac_pause_pkg::*;
#(
   parameter int          DATA_W       = 8,
   parameter logic [47:0] PAUSE_ADDR   = 48'h0180_C200_0001,
   parameter logic [15:0] CTRL_TYPE    = 16'h8808,
   parameter logic [15:0] PAUSE_OPCODE = 16'h0001
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_valid,
   input  logic [DATA_W-1:0] rx_data,
   input  logic              rx_sof,
   input  logic              rx_eof,
   input  logic              full_duplex,
   input  logic              rx_fc_en,
   output logic              frame_reject,
   output logic              pause_valid,
   output logic [15:0]       pause_quanta
);
   localparam int WORD_W = WORD_BYTES * DATA_W;

   generate
      if (DATA_W != BYTE_W) begin : g_bad_data
         $error("mac_pause_detect: byte path must be 8 bits");
      end
      if (WORD_W != 16) begin : g_bad_word
         $error("mac_pause_detect: control words must be 16 bits");
      end
   endgenerate

   logic                                 take, open, da_hit;
   logic [POS_W-1:0]                     pos, count;
   logic [NUM_WORDS-1:0][WORD_W-1:0]     words;
   verdict_e                             verdict;

   mac_pause_pos #(.LIMIT(LAST_POS), .CNT_W(POS_W)) u_pos (
      .clk(clk), .rst_n(rst_n), .byte_valid(rx_valid), .restart(rx_sof),
      .close(rx_eof), .take(take), .open(open), .pos(pos), .count(count));

   mac_pause_addr #(.DATA_W(DATA_W), .ADDR_BYTES(ADDR_BYTES), .CNT_W(POS_W),
                    .ADDR(PAUSE_ADDR)) u_addr (
      .clk(clk), .rst_n(rst_n), .take(take), .first(rx_sof), .close(rx_eof),
      .pos(pos), .data(rx_data), .match(da_hit));

   mac_pause_fields #(.DATA_W(DATA_W), .WORD_BYTES(WORD_BYTES),
                      .NUM_WORDS(NUM_WORDS), .BASE(OFS_TYPE),
                      .CNT_W(POS_W)) u_fields (
      .clk(clk), .rst_n(rst_n), .take(take), .pos(pos), .data(rx_data),
      .words(words));

   always_comb begin
      verdict = VERDICT_NONE;
      if (rx_eof && full_duplex && rx_fc_en && open && da_hit &&
          count >= POS_W'(OFS_OP)) begin
         if (words[0] != CTRL_TYPE) begin
            verdict = VERDICT_REJECT;
         end else if (count >= POS_W'(LAST_POS) && words[1] == PAUSE_OPCODE) begin
            verdict = VERDICT_PAUSE;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         frame_reject <= 1'b0;
         pause_valid  <= 1'b0;
         pause_quanta <= '0;
      end else begin
         frame_reject <= (verdict == VERDICT_REJECT);
         pause_valid  <= (verdict == VERDICT_PAUSE);
         if (verdict == VERDICT_PAUSE) pause_quanta <= words[2];
      end
   end

   p_gate_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_eof && !(full_duplex && rx_fc_en)) |=> !(pause_valid || frame_reject));
   p_reject_at_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
      frame_reject |-> $past(rx_eof));
   p_pause_at_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
      pause_valid |-> $past(rx_eof));
   p_single_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      pause_valid |=> !pause_valid);
   p_quanta_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !pause_valid |-> $stable(pause_quanta));
endmodule

// File: tb/mac_pause_detect_tb.sv
`timescale 1ns/1ps
module mac_pause_detect_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx_valid = 1'b0;
   logic [7:0]  rx_data = '0;
   logic        rx_sof = 1'b0;
   logic        rx_eof = 1'b0;
   logic        full_duplex = 1'b1;
   logic        rx_fc_en = 1'b1;
   logic        frame_reject, pause_valid;
   logic [15:0] pause_quanta;

   int checks = 0;
   int failures = 0;
   logic [7:0]  fb [0:63];
   logic        g_p, g_r;
   logic [15:0] g_q;

   always #2.5 clk = ~clk;

   mac_pause_detect u_dut (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
      .rx_sof(rx_sof), .rx_eof(rx_eof), .full_duplex(full_duplex),
      .rx_fc_en(rx_fc_en), .frame_reject(frame_reject),
      .pause_valid(pause_valid), .pause_quanta(pause_quanta));

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic build(input logic [7:0] da_last, input logic [15:0] typ,
                        input logic [15:0] op, input logic [15:0] q);
      for (int i = 0; i < 64; i++) fb[i] = 8'h00;
      fb[0] = 8'h01; fb[1] = 8'h80; fb[2] = 8'hC2;
      fb[3] = 8'h00; fb[4] = 8'h00; fb[5] = da_last;
      for (int i = 6; i < 12; i++) fb[i] = 8'h20 + 8'(i);
      fb[12] = typ[15:8]; fb[13] = typ[7:0];
      fb[14] = op[15:8];  fb[15] = op[7:0];
      fb[16] = q[15:8];   fb[17] = q[7:0];
   endtask

   task automatic send_bytes(input int len, input bit with_sof);
      for (int i = 0; i < len; i++) begin
         @(negedge clk);
         rx_sof   = with_sof && (i == 0);
         rx_valid = 1'b1;
         rx_data  = fb[i];
      end
   endtask

   task automatic finish_frame();
      @(negedge clk);
      rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b1;
      @(negedge clk);
      g_p = pause_valid; g_r = frame_reject; g_q = pause_quanta;
      rx_eof = 1'b0;
   endtask

   task automatic t_reset();
      chk("R9", "pause_valid", pause_valid, 0);
      chk("R9", "frame_reject", frame_reject, 0);
      chk("R9", "pause_quanta", pause_quanta, 0);
   endtask

   task automatic t_good_pause();
      build(8'h01, 16'h8808, 16'h0001, 16'h1234);
      send_bytes(60, 1); finish_frame();
      chk("R4", "pause_valid", g_p, 1);
      chk("R4", "pause_quanta", g_q, 16'h1234);
      chk("R4", "no reject", g_r, 0);
      @(negedge clk);
      chk("R6", "pulse one cycle", pause_valid, 0);
      chk("R6", "quanta held", pause_quanta, 16'h1234);
   endtask

   task automatic t_wrong_type();
      build(8'h01, 16'h0800, 16'h0001, 16'h7777);
      send_bytes(60, 1); finish_frame();
      chk("R3", "frame_reject", g_r, 1);
      chk("R3", "no pause", g_p, 0);
      @(negedge clk);
      chk("R3", "reject one cycle", frame_reject, 0);
      chk("R6", "quanta unchanged after reject", pause_quanta, 16'h1234);
   endtask

   task automatic t_wrong_addr();
      build(8'h02, 16'h8808, 16'h0001, 16'h4444);
      send_bytes(60, 1); finish_frame();
      chk("R2", "no pause", g_p, 0);
      chk("R2", "no reject", g_r, 0);
      build(8'h01, 16'h8808, 16'h0001, 16'h4444);
      fb[2] = 8'hC3;
      fb[12] = 8'h08; fb[13] = 8'h00;
      send_bytes(60, 1); finish_frame();
      chk("R2", "wrong byte 2 no reject", g_r, 0);
   endtask

   task automatic t_bad_opcode();
      build(8'h01, 16'h8808, 16'h0002, 16'h3333);
      send_bytes(60, 1); finish_frame();
      chk("R5", "no pause", g_p, 0);
      chk("R5", "no reject", g_r, 0);
      chk("R5", "quanta unchanged", g_q, 16'h1234);
   endtask

   task automatic t_gate();
      full_duplex = 1'b0;
      build(8'h01, 16'h8808, 16'h0001, 16'h1111);
      send_bytes(60, 1); finish_frame();
      chk("R1", "half duplex no pause", g_p, 0);
      build(8'h01, 16'h0800, 16'h0001, 16'h1111);
      send_bytes(60, 1); finish_frame();
      chk("R1", "half duplex no reject", g_r, 0);
      full_duplex = 1'b1; rx_fc_en = 1'b0;
      build(8'h01, 16'h8808, 16'h0001, 16'h1111);
      send_bytes(60, 1); finish_frame();
      chk("R1", "fc disabled no pause", g_p, 0);
      rx_fc_en = 1'b1;
   endtask

   task automatic t_short();
      build(8'h01, 16'h0800, 16'h0001, 16'h2222);
      send_bytes(13, 1); finish_frame();
      chk("R7", "13 bytes no reject", g_r, 0);
      build(8'h01, 16'h8808, 16'h0001, 16'h2222);
      send_bytes(17, 1); finish_frame();
      chk("R7", "17 bytes no pause", g_p, 0);
      send_bytes(18, 1); finish_frame();
      chk("R7", "18 bytes pause", g_p, 1);
      chk("R7", "18 bytes quanta", g_q, 16'h2222);
   endtask

   task automatic t_back_to_back();
      build(8'h01, 16'h8808, 16'h0001, 16'hABCD);
      send_bytes(60, 1);
      build(8'h01, 16'h8808, 16'h0001, 16'hFFFF);
      @(negedge clk);
      rx_eof = 1'b1; rx_sof = 1'b1; rx_valid = 1'b1; rx_data = fb[0];
      @(negedge clk);
      chk("R8", "first frame pause", pause_valid, 1);
      chk("R8", "first frame quanta", pause_quanta, 16'hABCD);
      rx_eof = 1'b0; rx_sof = 1'b0; rx_data = fb[1];
      for (int i = 2; i < 60; i++) begin
         @(negedge clk);
         rx_data = fb[i];
      end
      finish_frame();
      chk("R8", "second frame pause", g_p, 1);
      chk("R8", "second frame quanta", g_q, 16'hFFFF);
      chk("R8", "second frame no reject", g_r, 0);
   endtask

   task automatic t_restart();
      build(8'h01, 16'h0800, 16'h0001, 16'h9999);
      send_bytes(20, 1);
      build(8'h01, 16'h8808, 16'h0001, 16'h5555);
      send_bytes(60, 1); finish_frame();
      chk("R10", "restart pause", g_p, 1);
      chk("R10", "restart quanta", g_q, 16'h5555);
      chk("R10", "restart no reject", g_r, 0);
   endtask

   task automatic t_stray();
      build(8'h01, 16'h8808, 16'h0001, 16'h6666);
      send_bytes(60, 0); finish_frame();
      chk("R11", "stray bytes no pause", g_p, 0);
      chk("R11", "stray quanta unchanged", g_q, 16'h5555);
      finish_frame();
      chk("R11", "lone eof no reject", g_r, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_good_pause();
      t_wrong_type();
      t_wrong_addr();
      t_bad_opcode();
      t_gate();
      t_short();
      t_back_to_back();
      t_restart();
      t_stray();
      repeat (3) @(negedge clk);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      failures++;
      $display("FAIL watchdog run did not complete actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule